// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits in the issue stage of a pipeline that has four kinds of execution resource. The first is a single-cycle integer ALU. The second is the data-memory path used by loads. The third and fourth are a fully pipelined FP adder and a fully pipelined FP multiplier. There is also an FP divider that is not pipelined. Every operation that produces a register result writes it through one shared FP register-file write port.

The front end presents one candidate instruction per cycle. Each candidate carries:
- a unit code;
- a flag saying whether it writes a register;
- a destination register;
- two source registers.

In the same cycle, the interlock answers whether the instruction may issue. When it may not, the interlock reports why. There are four possible reasons:
- the divider is still occupied;
- the write-back slot the instruction would need is already taken;
- a source register still waits for an in-flight result;
- an older write to the same destination would land after this one.

State is held in three places. A write-back reservation shift register records which future cycles already own the write port. Each register has a countdown of the cycles left until its pending write lands. A busy counter covers the divider. Operand forwarding and the arithmetic itself lie outside this block.

Top module: `fp_issue_interlock`

## Requirements
- R1: An active-low asynchronous reset clears all write-port reservations, all pending-write countdowns and the divider busy state. After reset, any candidate issues whatever registers it names.
- R2: A divide (unit code 4) stalls with reason code 0 while a previous divide is in progress. A divide issued in cycle t lets the next divide issue no earlier than cycle t+24.
- R3: Add (unit code 2) and multiply (unit code 3) accept a new operation every cycle. Back-to-back adds and multiplies with independent registers and free write-back slots all issue.
- R4: A register-writing candidate whose write-back cycle is already claimed by an issued instruction stalls with reason code 1.
- R5: A candidate with either source register awaiting a pending write stalls with reason code 2. That stall lasts until the write-back cycle of the producer; in the write-back cycle itself the consumer may issue. A load feeding the very next instruction therefore costs one stall cycle.
- R6: A register-writing candidate whose destination has a pending write landing in the same cycle as its own write, or later, stalls with reason code 3.
- R7: A candidate whose own write would land after a pending write to the same destination is not stalled for that reason.
- R8: An instruction issued in cycle t writes back in cycle t+1 for the ALU (unit code 0), t+2 for a load (unit code 1), t+4 for an add, t+7 for a multiply and t+24 for a divide. Unit codes 5 to 7 behave as the ALU.
- R9: When several stall causes apply at once, the reported reason is the first of these, in this order: divider busy (0), port conflict (1), RAW (2), WAW (3).
- R10: With no valid candidate, both issue and stall are low. A candidate that does not write a register neither claims nor is checked against the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A candidate instruction is presented this cycle |
| req_unit | input | 3 | Unit code: 0 ALU, 1 load, 2 add, 3 multiply, 4 divide |
| req_wr | input | 1 | Candidate writes an FP register |
| req_dst | input | 5 | Destination register index |
| req_src_a | input | 5 | First source register index |
| req_src_b | input | 5 | Second source register index |
| issue | output | 1 | Candidate issues at the coming clock edge |
| stall | output | 1 | Candidate is held back this cycle |
| stall_why | output | 2 | Stall reason: 0 divider, 1 port, 2 RAW, 3 WAW (valid while stall is high) |

## Verification
The issue, stall and reason outputs are combinational on the candidate and the current state. The bench drives each candidate just after a rising edge and reads the verdict at the following falling edge, within the same cycle.

A candidate that issues changes state at the next rising edge. The bench therefore counts cycles from each issue:
- a RAW or WAW hazard clears in the producer's write-back cycle, one to twenty-four cycles later;
- a claimed port slot becomes visible at once to candidates whose write-back would fall on that cycle;
- a divide blocks the following divide for exactly the next twenty-three cycles.

The vector table is laid out so that every entry sits on the cycle at which those counts put it.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

   typedef enum logic [2:0] {
      UNIT_ALU  = 3'd0,
      UNIT_LOAD = 3'd1,
      UNIT_ADD  = 3'd2,
      UNIT_MUL  = 3'd3,
      UNIT_DIV  = 3'd4
   } unit_e;

   typedef enum logic [1:0] {
      WHY_DIV_BUSY = 2'd0,
      WHY_PORT     = 2'd1,
      WHY_RAW      = 2'd2,
      WHY_WAW      = 2'd3
   } why_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpi_wb_reserve.sv
module fpi_wb_reserve #(
   parameter int SLOTS = 25,
   parameter int DW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] probe_dly_i,
   input  logic          claim_i,
   output logic          taken_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("fpi_wb_reserve: SLOTS must be at least 2");
   end
   if ((1 << DW) < SLOTS) begin : g_bad_dw
      $error("fpi_wb_reserve: DW too narrow for SLOTS");
   end

   logic [SLOTS-1:0] slot_q;
   logic [SLOTS-1:0] slot_d;

   assign taken_o = slot_q[probe_dly_i];

   always_comb begin
      slot_d = slot_q >> 1;
      if (claim_i && (probe_dly_i != '0)) begin
         slot_d[probe_dly_i - DW'(1)] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
   end

   // R4: the write port is never claimed twice for the same cycle
   p_single_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      claim_i |-> !taken_o);

   // R8: a claim made at distance d is seen at distance d-1 one cycle later
   p_claim_ages_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_i && probe_dly_i > DW'(1)) |=> slot_q[$past(probe_dly_i) - DW'(1)]);

endmodule

// File: rtl/fpi_pend_table.sv
module fpi_pend_table #(
   parameter int NREG = 32,
   parameter int DW   = 5,
   localparam int RW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set_i,
   input  logic [RW-1:0]             set_idx_i,
   input  logic [DW-1:0]             set_val_i,
   output logic [NREG-1:0][DW-1:0]   left_o
);

   if (NREG < 2) begin : g_bad_nreg
      $error("fpi_pend_table: NREG must be at least 2");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DW-1:0] left_q;
      logic          hit;

      assign hit       = set_i && (set_idx_i == RW'(r));
      assign left_o[r] = left_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (hit)            left_q <= set_val_i;
         else if (left_q != '0)   left_q <= left_q - DW'(1);
      end

      // R5: a pending countdown drops by one each cycle until its write-back
      p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (left_q != '0 && !hit) |=> (left_q == $past(left_q) - DW'(1)));
   end

endmodule

// File: rtl/fpi_div_track.sv
module fpi_div_track #(
   parameter int II = 24,
   localparam int BW = $clog2(II + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   if (II < 2) begin : g_bad_ii
      $error("fpi_div_track: II must be at least 2");
   end

   logic [BW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             gap_q <= '0;
      else if (start_i)       gap_q <= BW'(II - 1);
      else if (gap_q != '0)   gap_q <= gap_q - BW'(1);
   end

   assign busy_o = (gap_q != '0);

   // R2: a divide start leaves the unit occupied in the following cycle
   p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
   import fpi_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int LAT_ALU = 0,
   parameter int LAT_MEM = 1,
   parameter int LAT_ADD = 3,
   parameter int LAT_MUL = 6,
   parameter int LAT_DIV = 23,
   parameter int DIV_II  = 24,
   localparam int RW     = $clog2(NREG),
   localparam int D_ALU  = LAT_ALU + 1,
   localparam int D_LOAD = LAT_MEM + 1,
   localparam int D_ADD  = LAT_ADD + 1,
   localparam int D_MUL  = LAT_MUL + 1,
   localparam int D_DIV  = LAT_DIV + 1,
   localparam int D_MAX  = max2(max2(max2(D_ALU, D_LOAD), max2(D_ADD, D_MUL)), D_DIV),
   localparam int SLOTS  = D_MAX + 1,
   localparam int DW     = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_unit,
   input  logic          req_wr,
   input  logic [RW-1:0] req_dst,
   input  logic [RW-1:0] req_src_a,
   input  logic [RW-1:0] req_src_b,
   output logic          issue,
   output logic          stall,
   output logic [1:0]    stall_why
);

   if (LAT_ALU < 0 || LAT_MEM < 0 || LAT_ADD < 0 || LAT_MUL < 0 || LAT_DIV < 0) begin : g_bad_lat
      $error("fp_issue_interlock: latencies must be non-negative");
   end
   if (DIV_II < 1) begin : g_bad_ii
      $error("fp_issue_interlock: DIV_II must be at least 1");
   end

   logic [DW-1:0]            dly;
   logic                     is_div;
   logic                     port_taken;
   logic                     div_busy;
   logic [NREG-1:0][DW-1:0]  left;
   logic                     hz_div, hz_port, hz_raw, hz_waw, hz_any;
   why_e                     why;

   always_comb begin
      case (unit_e'(req_unit))
         UNIT_LOAD: dly = DW'(D_LOAD);
         UNIT_ADD:  dly = DW'(D_ADD);
         UNIT_MUL:  dly = DW'(D_MUL);
         UNIT_DIV:  dly = DW'(D_DIV);
         default:   dly = DW'(D_ALU);
      endcase
   end

   assign is_div = (req_unit == UNIT_DIV);

   fpi_wb_reserve #(.SLOTS(SLOTS), .DW(DW)) u_reserve (
      .clk         (clk),
      .rst_n       (rst_n),
      .probe_dly_i (dly),
      .claim_i     (issue && req_wr),
      .taken_o     (port_taken)
   );

   fpi_pend_table #(.NREG(NREG), .DW(DW)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (issue && req_wr),
      .set_idx_i (req_dst),
      .set_val_i (dly - DW'(1)),
      .left_o    (left)
   );

   if (DIV_II > 1) begin : g_div_track
      fpi_div_track #(.II(DIV_II)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (issue && is_div),
         .busy_o  (div_busy)
      );
   end else begin : g_div_free
      assign div_busy = 1'b0;
   end

   assign hz_div  = is_div && div_busy;
   assign hz_port = req_wr && port_taken;
   assign hz_raw  = (left[req_src_a] != '0) || (left[req_src_b] != '0);
   assign hz_waw  = req_wr && (left[req_dst] != '0) && (left[req_dst] >= dly);
   assign hz_any  = hz_div || hz_port || hz_raw || hz_waw;

   always_comb begin
      if (hz_div)       why = WHY_DIV_BUSY;
      else if (hz_port) why = WHY_PORT;
      else if (hz_raw)  why = WHY_RAW;
      else              why = WHY_WAW;
   end

   assign issue     = req_valid && !hz_any;
   assign stall     = req_valid && hz_any;
   assign stall_why = why;

   // R2: a divide never issues while the divider is occupied
   p_div_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && is_div) |-> !div_busy);

   // R5: an issuing instruction sees no pending write on its sources
   p_sources_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (left[req_src_a] == '0 && left[req_src_b] == '0));

   // R6: an issuing writer lands strictly after any older write to its destination
   p_write_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && req_wr) |-> (left[req_dst] < dly));

   // R10: no candidate, no decision
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!issue && !stall));

endmodule

// File: tb/fp_issue_interlock_tb_top.sv
module fp_issue_interlock_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 17;

   typedef struct packed {
      logic       valid;
      logic [2:0] unit;
      logic       wr;
      logic [4:0] dst;
      logic [4:0] a;
      logic [4:0] b;
      logic       exp_issue;
      logic [1:0] exp_why;
      logic [3:0] req;
   } vec_t;

   // unit: 0 ALU 1 load 2 add 3 mul 4 div ; why: 0 div 1 port 2 RAW 3 WAW
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 3'd2, 1'b1, 5'd1,  5'd10, 5'd11, 1'b1, 2'd0, 4'd3},  // c0  add f1          R3
      '{1'b1, 3'd3, 1'b1, 5'd2,  5'd1,  5'd12, 1'b0, 2'd2, 4'd5},  // c1  mul uses f1     R5
      '{1'b1, 3'd3, 1'b1, 5'd2,  5'd12, 5'd13, 1'b1, 2'd0, 4'd3},  // c2  mul f2 wb c9    R3
      '{1'b1, 3'd2, 1'b1, 5'd3,  5'd14, 5'd15, 1'b1, 2'd0, 4'd3},  // c3  add f3 wb c7    R3
      '{1'b1, 3'd0, 1'b1, 5'd4,  5'd1,  5'd0,  1'b1, 2'd0, 4'd5},  // c4  f1 wb cycle     R5
      '{1'b1, 3'd0, 1'b1, 5'd5,  5'd1,  5'd3,  1'b0, 2'd2, 4'd5},  // c5  f3 pending      R5
      '{1'b1, 3'd2, 1'b1, 5'd2,  5'd1,  5'd0,  1'b1, 2'd0, 4'd7},  // c6  add f2 later    R7
      '{1'b1, 3'd0, 1'b1, 5'd2,  5'd0,  5'd0,  1'b0, 2'd3, 4'd6},  // c7  alu f2 earlier  R6
      '{1'b1, 3'd2, 1'b1, 5'd6,  5'd20, 5'd21, 1'b1, 2'd0, 4'd8},  // c8  add wb c12      R8
      '{1'b1, 3'd1, 1'b1, 5'd7,  5'd0,  5'd0,  1'b1, 2'd0, 4'd8},  // c9  load wb c11     R8
      '{1'b1, 3'd0, 1'b1, 5'd8,  5'd0,  5'd0,  1'b0, 2'd1, 4'd4},  // c10 alu wb c11      R4
      '{1'b1, 3'd1, 1'b1, 5'd16, 5'd0,  5'd0,  1'b1, 2'd0, 4'd8},  // c11 load f16        R8
      '{1'b1, 3'd3, 1'b1, 5'd17, 5'd16, 5'd0,  1'b0, 2'd2, 4'd5},  // c12 load-use stall  R5
      '{1'b1, 3'd3, 1'b1, 5'd17, 5'd16, 5'd0,  1'b1, 2'd0, 4'd5},  // c13 mul wb c20      R5
      '{1'b1, 3'd0, 1'b1, 5'd18, 5'd17, 5'd0,  1'b0, 2'd2, 4'd5},  // c14 f17 pending     R5
      '{1'b0, 3'd0, 1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 2'd0, 4'd10}, // c15 idle            R10
      '{1'b1, 3'd2, 1'b1, 5'd21, 5'd17, 5'd0,  1'b0, 2'd1, 4'd9}   // c16 port+RAW        R9
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_unit = 3'd0;
   logic       req_wr = 1'b0;
   logic [4:0] req_dst = 5'd0;
   logic [4:0] req_src_a = 5'd0;
   logic [4:0] req_src_b = 5'd0;
   logic       issue;
   logic       stall;
   logic [1:0] stall_why;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_issue_interlock dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_unit  (req_unit),
      .req_wr    (req_wr),
      .req_dst   (req_dst),
      .req_src_a (req_src_a),
      .req_src_b (req_src_b),
      .issue     (issue),
      .stall     (stall),
      .stall_why (stall_why)
   );

   task automatic drive(input logic v, input logic [2:0] u, input logic w,
                        input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
      req_valid = v; req_unit = u; req_wr = w;
      req_dst = d; req_src_a = a; req_src_b = b;
   endtask

   task automatic expect_out(input string tag, input logic e_issue, input logic e_stall,
                             input logic [1:0] e_why);
      checks++;
      if (issue !== e_issue || stall !== e_stall || (e_stall && stall_why !== e_why)) begin
         errors++;
         $display("FAIL %s: issue=%0b stall=%0b why=%0d, expected issue=%0b stall=%0b why=%0d",
                  tag, issue, stall, stall_why, e_issue, e_stall, e_why);
      end
   endtask

   task automatic step(input logic v, input logic [2:0] u, input logic w,
                       input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
      @(posedge clk); #1;
      drive(v, u, w, d, a, b);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      drive(1'b0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      expect_out("R10 idle after reset", 1'b0, 1'b0, 2'd0);

      for (int i = 0; i < NVEC; i++) begin
         step(VECS[i].valid, VECS[i].unit, VECS[i].wr, VECS[i].dst, VECS[i].a, VECS[i].b);
         expect_out($sformatf("R%0d table vector %0d", VECS[i].req, i),
                    VECS[i].exp_issue, VECS[i].valid && !VECS[i].exp_issue, VECS[i].exp_why);
      end

      // drain
      for (int k = 0; k < 30; k++) step(1'b0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);

      // R2: divider interval of 24 cycles
      step(1'b1, 3'd4, 1'b1, 5'd20, 5'd0, 5'd0);
      expect_out("R2 first divide", 1'b1, 1'b0, 2'd0);
      for (int k = 1; k <= 24; k++) begin
         step(1'b1, 3'd4, 1'b1, 5'd22, 5'd0, 5'd0);
         if (k < 24) expect_out($sformatf("R2 divide gap %0d", k), 1'b0, 1'b1, 2'd0);
         else        expect_out("R2 divide at gap 24", 1'b1, 1'b0, 2'd0);
      end

      // R3: back-to-back add, add, mul
      step(1'b1, 3'd2, 1'b1, 5'd23, 5'd0, 5'd0);
      expect_out("R3 add back-to-back 1", 1'b1, 1'b0, 2'd0);
      step(1'b1, 3'd2, 1'b1, 5'd24, 5'd0, 5'd0);
      expect_out("R3 add back-to-back 2", 1'b1, 1'b0, 2'd0);
      step(1'b1, 3'd3, 1'b1, 5'd26, 5'd0, 5'd0);
      expect_out("R3 mul after adds", 1'b1, 1'b0, 2'd0);

      // R10: a non-writing ALU op on the slot claimed by the mul (wb 7 cycles out)
      for (int k = 0; k < 5; k++) step(1'b0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);
      step(1'b1, 3'd0, 1'b0, 5'd9, 5'd0, 5'd0);
      expect_out("R10 non-writer ignores port", 1'b1, 1'b0, 2'd0);

      // R1: reset mid-flight clears pending, port and divider state
      step(1'b1, 3'd3, 1'b1, 5'd25, 5'd0, 5'd0);
      expect_out("R1 mul before reset", 1'b1, 1'b0, 2'd0);
      step(1'b1, 3'd4, 1'b1, 5'd28, 5'd25, 5'd0);
      expect_out("R1 pre-reset check divide stalls", 1'b0, 1'b1, 2'd0);
      @(posedge clk); #1;
      drive(1'b0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      step(1'b1, 3'd4, 1'b1, 5'd28, 5'd25, 5'd0);
      expect_out("R1 divide after reset", 1'b1, 1'b0, 2'd0);

      step(1'b0, 3'd0, 1'b0, 5'd0, 5'd0, 5'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule